// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block holds the valid flags of an in-order instruction pipeline and computes, every cycle, which stage may advance. The stages run in this order: instruction fetch, decode, operand read, then a combined execute stage that serves both the ALU and memory tracks. The controller does not see any instruction data. It works from abstract status only: whether a fetched word is available, a local busy request from each stage, a pending-branch flag, a program-counter discontinuity, a sleep request, and register write-back requests from the ALU and memory tracks.

Each stage receives a valid, a stall and a clock enable signal. Stalls propagate backwards only through occupied stages, so bubbles are squeezed out behind a blocked stage. A PC discontinuity empties every stage that precedes execute. An instruction that has reached execute always completes. When both tracks want the register file in the same cycle, the memory track gets it.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `stage_valid` is 0 at once, without waiting for a clock edge, and so every `stage_stall` bit is 0 and every `stage_ce` bit is 1.
- R2: For every stage, `stage_ce` is the inverse of `stage_stall` in every cycle.
- R3: Stage index 0 is fetch, 1 decode, NSTAGE-2 operand read and NSTAGE-1 execute. A stage before execute stalls exactly when it is valid and either its `stage_busy` bit is set or the next stage is stalled. An empty stage never stalls, whatever its busy bit says.
- R4: A valid, unstalled stage hands its instruction to the next stage at the next edge. A stalled stage stays valid. The fetch stage becomes valid when `fetch_ok` is high and the stage is not stalled. All of this applies only when `new_pc` is low.
- R5: When `new_pc` is high, every stage before execute is invalid after the next edge, even if it was stalled. The instruction in operand read does not enter execute.
- R6: A stalled execute stage is still valid after the next edge, even when `new_pc` is high.
- R7: A valid operand-read stage stalls while `branch_pending` is high.
- R8: A valid execute stage stalls while `sleep_req` is high, and the stall backs up through the occupied stages before it.
- R9: `wb_grant_mem` follows `mem_wb_req`. `wb_grant_alu` is high only when `alu_wb_req` is high, execute is valid and not stalled, and `mem_wb_req` is low. When both requests are high, the execute stage stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_ok | input | 1 | An instruction word is available to the fetch stage |
| stage_busy | input | NSTAGE | Per-stage local hold request (memory busy, operand pending, etc.) |
| branch_pending | input | 1 | A possibly PC-changing instruction is still resolving in execute |
| new_pc | input | 1 | PC discontinuity (jump, interrupt, return) |
| sleep_req | input | 1 | Sleep condition holds |
| alu_wb_req | input | 1 | ALU track wants a register write |
| mem_wb_req | input | 1 | Memory track wants a register write |
| stage_valid | output | NSTAGE | Stage holds a live instruction |
| stage_stall | output | NSTAGE | Stage must hold its contents |
| stage_ce | output | NSTAGE | Stage register may load |
| wb_grant_alu | output | 1 | ALU result written this cycle |
| wb_grant_mem | output | 1 | Memory result written this cycle |

## Verification
The bench builds the block with the default NSTAGE of 4. With that value, fetch and decode are separate from both operand read and execute, so the stall chain has four links. A stall raised in execute or operand read can then be seen reaching a stage that has no special condition of its own. Four stages also let one run fill the whole pipe and then hit it with a flush, a sleep or a write-back conflict. It can also isolate a single instruction moving stage by stage, which shows that bubbles never stall and that execute survives a flush.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Write-back port selection
  typedef enum logic [1:0] {
    WB_IDLE = 2'd0,
    WB_ALU  = 2'd1,
    WB_MEM  = 2'd2
  } wb_sel_e;
endpackage

// File: rtl/hz_stall_chain.sv
// Backward stall propagation: a stage holds when it is occupied and either
// it is locally blocked or its successor holds.
module hz_stall_chain #(
  parameter int NSTAGE = 4
) (
  input  logic [NSTAGE-1:0] valid_i,
  input  logic [NSTAGE-1:0] busy_i,
  input  logic              hold_op_i,
  input  logic              hold_ex_i,
  output logic [NSTAGE-1:0] stall_o
);
  localparam int OP_IDX = NSTAGE - 2;

  logic carry;

  always_comb begin
    carry   = hold_ex_i;
    stall_o = '0;
    for (int i = NSTAGE - 1; i >= 0; i--) begin
      stall_o[i] = valid_i[i] &
                   (busy_i[i] | carry | ((i == OP_IDX) & hold_op_i));
      carry      = stall_o[i];
    end
  end
endmodule

// File: rtl/hz_wb_arb.sv
// Register-file write port arbitration, memory track first.
module hz_wb_arb
  import hz_pkg::*;
(
  input  logic    alu_req_i,
  input  logic    mem_req_i,
  input  logic    ex_valid_i,
  input  logic    ex_hold_i,
  output wb_sel_e sel_o,
  output logic    alu_lost_o
);
  always_comb begin
    alu_lost_o = alu_req_i & mem_req_i;
    if (mem_req_i) begin
      sel_o = WB_MEM;
    end else if (alu_req_i & ex_valid_i & ~ex_hold_i) begin
      sel_o = WB_ALU;
    end else begin
      sel_o = WB_IDLE;
    end
  end
endmodule

// File: rtl/hz_stage_reg.sv
// Occupancy flag of one pipeline stage.
module hz_stage_reg #(
  parameter bit FLUSHABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_i,
  input  logic stall_i,
  input  logic flush_i,
  output logic valid_o
);
  logic valid_q;
  logic valid_d;

  always_comb begin
    if (stall_i) begin
      valid_d = valid_q & ~(FLUSHABLE & flush_i);
    end else begin
      valid_d = fill_i & ~flush_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int NSTAGE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_ok,
  input  logic [NSTAGE-1:0] stage_busy,
  input  logic              branch_pending,
  input  logic              new_pc,
  input  logic              sleep_req,
  input  logic              alu_wb_req,
  input  logic              mem_wb_req,
  output logic [NSTAGE-1:0] stage_valid,
  output logic [NSTAGE-1:0] stage_stall,
  output logic [NSTAGE-1:0] stage_ce,
  output logic              wb_grant_alu,
  output logic              wb_grant_mem
);
  localparam int EX_IDX = NSTAGE - 1;

  wb_sel_e           wb_sel;
  logic              alu_lost;
  logic              ex_hold;
  logic [NSTAGE-1:0] fill;

  hz_wb_arb u_arb (
    .alu_req_i  (alu_wb_req),
    .mem_req_i  (mem_wb_req),
    .ex_valid_i (stage_valid[EX_IDX]),
    .ex_hold_i  (stage_busy[EX_IDX] | sleep_req),
    .sel_o      (wb_sel),
    .alu_lost_o (alu_lost)
  );

  assign ex_hold = sleep_req | alu_lost;

  hz_stall_chain #(.NSTAGE(NSTAGE)) u_chain (
    .valid_i   (stage_valid),
    .busy_i    (stage_busy),
    .hold_op_i (branch_pending),
    .hold_ex_i (ex_hold),
    .stall_o   (stage_stall)
  );

  assign fill[0] = fetch_ok;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign fill[i] = stage_valid[i-1] & ~stage_stall[i-1];
    end
    hz_stage_reg #(.FLUSHABLE(i != EX_IDX)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .fill_i  (fill[i]),
      .stall_i (stage_stall[i]),
      .flush_i (new_pc),
      .valid_o (stage_valid[i])
    );
  end

  assign stage_ce     = ~stage_stall;
  assign wb_grant_alu = (wb_sel == WB_ALU);
  assign wb_grant_mem = (wb_sel == WB_MEM);
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int NSTAGE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              new_pc,
  input logic              branch_pending,
  input logic              sleep_req,
  input logic              alu_wb_req,
  input logic              mem_wb_req,
  input logic [NSTAGE-1:0] stage_valid,
  input logic [NSTAGE-1:0] stage_stall,
  input logic              wb_grant_alu,
  input logic              wb_grant_mem
);
  localparam int EX_IDX = NSTAGE - 1;
  localparam int OP_IDX = NSTAGE - 2;

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (stage_valid == '0);
    end
  end

  // R5
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_pc |=> (stage_valid[OP_IDX:0] == '0));

  // R6
  ex_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_stall[EX_IDX] |=> stage_valid[EX_IDX]);

  // R7
  branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_pending && stage_valid[OP_IDX]) |-> stage_stall[OP_IDX]);

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && stage_valid[EX_IDX]) |-> stage_stall[EX_IDX]);

  // R9
  mem_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_wb_req && mem_wb_req) |-> (!wb_grant_alu && wb_grant_mem));

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_grant_alu, wb_grant_mem}));

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stg
    // R3
    bubble_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_valid[i] |-> !stage_stall[i]);
    if (i < EX_IDX) begin : g_early
      // R4
      advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_valid[i] && !stage_stall[i] && !new_pc) |=> stage_valid[i+1]);
      // R4
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_stall[i] && !new_pc) |=> stage_valid[i]);
    end
  end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.NSTAGE(NSTAGE)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .new_pc         (new_pc),
  .branch_pending (branch_pending),
  .sleep_req      (sleep_req),
  .alu_wb_req     (alu_wb_req),
  .mem_wb_req     (mem_wb_req),
  .stage_valid    (stage_valid),
  .stage_stall    (stage_stall),
  .wb_grant_alu   (wb_grant_alu),
  .wb_grant_mem   (wb_grant_mem)
);

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;
  localparam int NSTAGE = 4;
  localparam int NVEC   = 20;

  logic              clk;
  logic              rst_n;
  logic              fetch_ok;
  logic [NSTAGE-1:0] stage_busy;
  logic              branch_pending, new_pc, sleep_req, alu_wb_req, mem_wb_req;
  logic [NSTAGE-1:0] stage_valid, stage_stall, stage_ce;
  logic              wb_grant_alu, wb_grant_mem;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  pipe_hazard_ctrl #(.NSTAGE(NSTAGE)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_ok(fetch_ok), .stage_busy(stage_busy),
    .branch_pending(branch_pending), .new_pc(new_pc), .sleep_req(sleep_req),
    .alu_wb_req(alu_wb_req), .mem_wb_req(mem_wb_req),
    .stage_valid(stage_valid), .stage_stall(stage_stall), .stage_ce(stage_ce),
    .wb_grant_alu(wb_grant_alu), .wb_grant_mem(wb_grant_mem)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Row: {fetch, busy[3:0], {branch,newpc,sleep,alu,mem}, valid[3:0], stall[3:0], {galu,gmem}}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 4'b0000, 5'b00000, 4'b0000, 4'b0000, 2'b00},  // 0  R4 fill
    {1'b1, 4'b0000, 5'b00000, 4'b0001, 4'b0000, 2'b00},  // 1
    {1'b1, 4'b0000, 5'b00000, 4'b0011, 4'b0000, 2'b00},  // 2
    {1'b1, 4'b0000, 5'b00000, 4'b0111, 4'b0000, 2'b00},  // 3
    {1'b1, 4'b0000, 5'b00010, 4'b1111, 4'b0000, 2'b10},  // 4  R9 alu alone
    {1'b1, 4'b0000, 5'b00100, 4'b1111, 4'b1111, 2'b00},  // 5  R8 sleep
    {1'b1, 4'b0000, 5'b00011, 4'b1111, 4'b1111, 2'b01},  // 6  R9 conflict
    {1'b1, 4'b0000, 5'b00001, 4'b1111, 4'b0000, 2'b01},  // 7  R9 mem alone
    {1'b1, 4'b0000, 5'b10000, 4'b1111, 4'b0111, 2'b00},  // 8  R7 branch
    {1'b1, 4'b0010, 5'b01000, 4'b0111, 4'b0011, 2'b00},  // 9  R5 flush+stall
    {1'b0, 4'b1111, 5'b00000, 4'b0000, 4'b0000, 2'b00},  // 10 R5 emptied, R3 bubbles
    {1'b1, 4'b0001, 5'b00000, 4'b0000, 4'b0000, 2'b00},  // 11 R3
    {1'b1, 4'b0001, 5'b00000, 4'b0001, 4'b0001, 2'b00},  // 12 R3 fetch busy
    {1'b0, 4'b0000, 5'b00000, 4'b0001, 4'b0000, 2'b00},  // 13
    {1'b0, 4'b0000, 5'b00000, 4'b0010, 4'b0000, 2'b00},  // 14
    {1'b0, 4'b0100, 5'b00000, 4'b0100, 4'b0100, 2'b00},  // 15 R3 operand busy
    {1'b0, 4'b0000, 5'b00000, 4'b0100, 4'b0000, 2'b00},  // 16
    {1'b0, 4'b1000, 5'b01000, 4'b1000, 4'b1000, 2'b00},  // 17 R6 ex busy + flush
    {1'b0, 4'b0000, 5'b00010, 4'b1000, 4'b0000, 2'b10},  // 18 R6 survived
    {1'b0, 4'b0000, 5'b00011, 4'b0000, 4'b0000, 2'b01}   // 19 R9 empty ex
  };

  function automatic string row_tag(int k);
    case (k)
      4, 6, 7, 19: return "R9";
      5:           return "R8";
      8:           return "R7";
      9, 10:       return "R5";
      11, 12, 15:  return "R3";
      17, 18:      return "R6";
      default:     return "R4";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    fetch_ok = 1'b0; stage_busy = '0; branch_pending = 1'b0; new_pc = 1'b0;
    sleep_req = 1'b0; alu_wb_req = 1'b0; mem_wb_req = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid in reset", stage_valid, 4'b0000);
    chk("R1", "stall in reset", stage_stall, 4'b0000);
    chk("R1", "ce in reset", stage_ce, 4'b1111);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      fetch_ok   = VEC[k][19];
      stage_busy = VEC[k][18:15];
      {branch_pending, new_pc, sleep_req, alu_wb_req, mem_wb_req} = VEC[k][14:10];
      #5;
      chk(row_tag(k), "valid", stage_valid, VEC[k][9:6]);
      chk(row_tag(k), "stall", stage_stall, VEC[k][5:2]);
      chk("R2", "ce", stage_ce, ~VEC[k][5:2]);
      chk(row_tag(k), "grants", {2'b00, wb_grant_alu, wb_grant_mem}, {2'b00, VEC[k][1:0]});
    end

    // R1: reset asserted mid-run clears a full pipe at once
    @(negedge clk);
    idle_inputs();
    fetch_ok = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    chk("R4", "valid full", stage_valid, 4'b1111);
    sleep_req = 1'b1;
    #1;
    chk("R8", "stall sleeping", stage_stall, 4'b1111);
    rst_n = 1'b0;
    #1;
    chk("R1", "valid async clear", stage_valid, 4'b0000);
    chk("R1", "stall async clear", stage_stall, 4'b0000);
    chk("R1", "ce async clear", stage_ce, 4'b1111);
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b1;

    // R6 / R5: flush while execute is busy
    fetch_ok = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    chk("R4", "valid refill", stage_valid, 4'b1111);
    @(negedge clk);
    stage_busy = 4'b1000;
    new_pc     = 1'b1;
    #5;
    chk("R3", "stall chain from ex", stage_stall, 4'b1111);
    @(negedge clk);
    idle_inputs();
    #5;
    chk("R6", "valid after flush", stage_valid, 4'b1000);
    @(negedge clk);
    #5;
    chk("R6", "valid drained", stage_valid, 4'b0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule